// File: doc/BRIEF.md
# Dual-Mode Cascadable Pulse Accumulator

This block accumulates activity seen on one asynchronous timer input pin. In event mode it adds one for every edge of the selected polarity. In gated time mode it adds one for every tick of a free-running divide-by-64 prescaler, but only while the pin sits at the selected active level. The same pin and the same polarity bit serve both modes.

The accumulator is built from two 8-bit count bytes. When the system enable is set, the two bytes form one 16-bit counter, with the upper byte taking the carry of the lower byte. When the system enable is clear, each byte counts on its own under its own enable bit, and the edge flag is never set. Software can load either byte through a small write port. It clears the edge flag by writing a one to the clear input.

Top module: `pacc_top`

## Requirements
- R1: After reset both count bytes read 0x00 and the edge flag reads 0.
- R2: With `sys_en`=1 the bytes form one 16-bit count with `cnt_hi` as the upper byte. The low byte wraps from 0xFF to 0x00 and carries one into the high byte. 0xFFFF wraps to 0x0000.
- R3: With `sys_en`=1 the levels of `lo_en` and `hi_en` have no effect on counting.
- R4: With `mode_gated`=0, `edge_sel`=0 adds one on each falling pin edge and `edge_sel`=1 adds one on each rising pin edge. Edges of the other polarity add nothing.
- R5: With `mode_gated`=1 and `edge_sel`=0, the count advances once per 64 clock cycles while the pin is high. A high interval of exactly N×64 cycles adds exactly N. A low interval adds nothing.
- R6: With `mode_gated`=1 and `edge_sel`=1, the count advances once per 64 clock cycles while the pin is low. A low interval of exactly N×64 cycles adds exactly N.
- R7: With `sys_en`=1, `flag_o` is set by the counted edge in event mode. In gated mode it is set by the edge that ends the active interval (falling for `edge_sel`=0, rising for `edge_sel`=1). It is not set by the edge that starts the active interval. With `sys_en`=0 it is never set.
- R8: With `sys_en`=0 the low byte counts only while `lo_en`=1 and the high byte only while `hi_en`=1. No carry passes between them.
- R9: A write with `wr_en`=1 loads `wr_data` into the low byte when `wr_sel`=0 and into the high byte when `wr_sel`=1, visible after the next clock edge. It wins over an increment in the same cycle, and a low-byte write suppresses that cycle's carry.
- R10: `flag_clr`=1 clears `flag_o` on the next edge. A flag set in the same cycle wins over the clear.
- R11: In independent mode a byte wraps from 0xFF to 0x00 without changing the other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 1 | Asynchronous timer input pin |
| sys_en | input | 1 | 1: cascaded 16-bit counter with edge flag; 0: independent bytes |
| mode_gated | input | 1 | 0: event counting; 1: gated time accumulation |
| edge_sel | input | 1 | Polarity select (see R4 to R7) |
| lo_en | input | 1 | Low byte enable in independent mode |
| hi_en | input | 1 | High byte enable in independent mode |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | Byte select for writes: 0 low, 1 high |
| wr_data | input | 8 | Write data |
| flag_clr | input | 1 | Write-one-to-clear for the edge flag |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| flag_o | output | 1 | Input edge flag |

## Verification
Event counting is driven with bursts of full pulses under both polarities. Every pulse has exactly one edge of each kind, so a count that matches the pulse number proves only one polarity is counted. Gated counting holds the pin at a level for exact multiples of 64 cycles and then leaves it at the inactive level. This separates correct gating from counting on the wrong level, and it holds whatever the prescaler phase is. The flag is checked after the leading edge and after the trailing edge to tell the two apart. Preloads near 0xFF and 0xFFFF, a write timed onto a measured prescaler tick, and runs with the per-byte enables set both ways separate carry, wrap, write priority and cascaded from independent operation.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  typedef enum logic {
    ACC_EVENT = 1'b0,
    ACC_GATED = 1'b1
  } acc_mode_e;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } pin_evt_t;

endpackage

// File: rtl/pacc_rst_sync.sv
module pacc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/pacc_pin_sync.sv
module pacc_pin_sync
  import pacc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_i,
  output pin_evt_t evt_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin_i};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  always_comb begin
    evt_o.lvl  = chain_q[STAGES-1];
    evt_o.rise = chain_q[STAGES-1] & ~prev_q;
    evt_o.fall = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
  parameter int DIV_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;

  always_comb begin
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = &div_q;
endmodule

// File: rtl/pacc_byte_cnt.sv
module pacc_byte_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o,
  output logic         full_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = ld_i | inc_i;
    if (ld_i) cnt_d = ld_val_i;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign q_o    = cnt_q;
  assign full_o = &cnt_q;
endmodule

// File: rtl/pacc_top.sv
module pacc_top
  import pacc_pkg::*;
#(
  parameter int W           = 8,
  parameter int DIV_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_i,
  input  logic         sys_en,
  input  logic         mode_gated,
  input  logic         edge_sel,
  input  logic         lo_en,
  input  logic         hi_en,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         flag_clr,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         flag_o
);
  localparam int NB = 2;

  logic              rst_sync_n;
  pin_evt_t          evt;
  logic              tick;
  acc_mode_e         mode;
  logic              qual_edge;
  logic              level_ok;
  logic              step;
  logic [NB-1:0]     ld;
  logic [NB-1:0]     inc;
  logic [NB-1:0]     full;
  logic [NB-1:0]     byte_en;
  logic [NB-1:0][W-1:0] cnt;
  logic              flag_q;
  logic              flag_d;
  logic              flag_set;

  pacc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pacc_pin_sync #(.STAGES(SYNC_STAGES)) i_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pin_i (pin_i),
    .evt_o (evt)
  );

  pacc_prescale #(.DIV_W(DIV_W)) i_prescale (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_o (tick)
  );

  // Event qualification shared by both modes: the counted edge in event
  // mode is also the trailing edge of the active level in gated mode.
  always_comb begin
    mode      = acc_mode_e'(mode_gated);
    qual_edge = edge_sel ? evt.rise : evt.fall;
    level_ok  = edge_sel ? ~evt.lvl : evt.lvl;
    step      = (mode == ACC_GATED) ? (tick & level_ok) : qual_edge;
    byte_en   = {hi_en, lo_en};
  end

  generate
    for (genvar g = 0; g < NB; g++) begin : g_byte
      assign ld[g] = wr_en && (wr_sel == 1'(g));

      if (g == 0) begin : g_low
        assign inc[g] = step & (sys_en | byte_en[g]);
      end else begin : g_upper
        assign inc[g] = sys_en ? (step & full[g-1] & ~ld[g-1] & inc[g-1])
                               : (step & byte_en[g]);
      end

      pacc_byte_cnt #(.W(W)) i_byte (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .ld_i     (ld[g]),
        .ld_val_i (wr_data),
        .inc_i    (inc[g]),
        .q_o      (cnt[g]),
        .full_o   (full[g])
      );
    end
  endgenerate

  always_comb begin
    flag_set = sys_en & qual_edge;
    if (flag_set)      flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flag_q <= 1'b0;
    else             flag_q <= flag_d;
  end

  assign cnt_lo = cnt[0];
  assign cnt_hi = cnt[1];
  assign flag_o = flag_q;
endmodule

// File: rtl/pacc_top_chk.sv
module pacc_top_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sys_en,
  input logic         lo_en,
  input logic         wr_en,
  input logic         wr_sel,
  input logic [W-1:0] wr_data,
  input logic         flag_clr,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic         flag_o
);
  // R7: with the system enable off, a clear flag stays clear
  a_r7_flag_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_en && !flag_o) |=> !flag_o);

  // R10: clear wins when no set is possible
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !sys_en) |=> !flag_o);

  // R9: a low-byte write lands on the next edge
  a_r9_wr_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (cnt_lo == $past(wr_data)));

  // R9: a high-byte write lands on the next edge
  a_r9_wr_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (cnt_hi == $past(wr_data)));

  // R8: a disabled independent low byte holds
  a_r8_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_en && !lo_en && !(wr_en && !wr_sel)) |=> $stable(cnt_lo));

  // R4: without writes the low byte moves by at most one
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel) |=>
      ((cnt_lo == $past(cnt_lo)) || (cnt_lo == W'($past(cnt_lo) + 1'b1))));

  // R2: in cascade the high byte only moves on a low-byte carry
  a_r2_hi_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_en && !wr_en && !(&cnt_lo)) |=> $stable(cnt_hi));
endmodule

bind pacc_top pacc_top_chk #(.W(W)) i_pacc_top_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .sys_en   (sys_en),
  .lo_en    (lo_en),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .flag_clr (flag_clr),
  .cnt_lo   (cnt_lo),
  .cnt_hi   (cnt_hi),
  .flag_o   (flag_o)
);

// File: tb/test_pacc_top.sv
`timescale 1ns/1ps
module test_pacc_top;
  logic       clk;
  logic       rst_n;
  logic       pin_i;
  logic       sys_en;
  logic       mode_gated;
  logic       edge_sel;
  logic       lo_en;
  logic       hi_en;
  logic       wr_en;
  logic       wr_sel;
  logic [7:0] wr_data;
  logic       flag_clr;
  logic [7:0] cnt_lo;
  logic [7:0] cnt_hi;
  logic       flag_o;

  int n_chk;
  int n_bad;

  pacc_top i_pacc_top (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sys_en(sys_en),
    .mode_gated(mode_gated), .edge_sel(edge_sel), .lo_en(lo_en),
    .hi_en(hi_en), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .flag_clr(flag_clr), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .flag_o(flag_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic sel, input logic [7:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin_i = 1'b1; step(4);
      pin_i = 1'b0; step(4);
    end
  endtask

  task automatic t_reset();
    chk("R1 count after reset", {cnt_hi, cnt_lo}, 16'h0000);
    chk("R1 flag after reset", {15'd0, flag_o}, 16'h0000);
  endtask

  task automatic t_event_fall();
    sys_en = 1; mode_gated = 0; edge_sel = 0;
    pulses(5);
    chk("R4 falling edges counted", {cnt_hi, cnt_lo}, 16'd5);
    chk("R7 flag on counted edge", {15'd0, flag_o}, 16'd1);
    clr_flag();
    chk("R10 flag cleared", {15'd0, flag_o}, 16'd0);
  endtask

  task automatic t_event_rise();
    edge_sel = 1;
    wr_byte(0, 8'h00); wr_byte(1, 8'h00);
    pin_i = 1'b1; step(5);
    chk("R4 one rising edge", {cnt_hi, cnt_lo}, 16'd1);
    pin_i = 1'b0; step(5);
    chk("R4 falling edge ignored", {cnt_hi, cnt_lo}, 16'd1);
    pulses(2);
    chk("R4 rising edges counted", {cnt_hi, cnt_lo}, 16'd3);
    // set and clear in the same cycle: set must win
    clr_flag();
    pin_i = 1'b1; step(2);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    step(2);
    chk("R10 set wins over clear", {15'd0, flag_o}, 16'd1);
    pin_i = 1'b0; step(4);
    clr_flag();
  endtask

  task automatic t_carry();
    lo_en = 0; hi_en = 0;
    wr_byte(0, 8'hFE); wr_byte(1, 8'h12);
    pulses(3);
    chk("R2 R3 carry into high byte", {cnt_hi, cnt_lo}, 16'h1301);
    wr_byte(0, 8'hFF); wr_byte(1, 8'hFF);
    pulses(1);
    chk("R2 16-bit wrap", {cnt_hi, cnt_lo}, 16'h0000);
    lo_en = 1; hi_en = 1;
    pulses(2);
    chk("R3 enables have no effect", {cnt_hi, cnt_lo}, 16'h0002);
    lo_en = 0; hi_en = 0;
    clr_flag();
  endtask

  task automatic t_gated_high();
    mode_gated = 1; edge_sel = 0; pin_i = 0;
    step(4);
    wr_byte(0, 8'h00); wr_byte(1, 8'h00);
    clr_flag();
    pin_i = 1'b1; step(10);
    chk("R7 leading edge sets no flag", {15'd0, flag_o}, 16'd0);
    step(182);
    pin_i = 1'b0; step(6);
    chk("R5 three ticks while high", {cnt_hi, cnt_lo}, 16'd3);
    chk("R7 trailing falling edge flag", {15'd0, flag_o}, 16'd1);
    step(128);
    chk("R5 no count while low", {cnt_hi, cnt_lo}, 16'd3);
  endtask

  task automatic t_gated_low();
    pin_i = 1'b1; step(4);
    edge_sel = 1; step(1);
    wr_byte(0, 8'h00); wr_byte(1, 8'h00);
    clr_flag();
    step(128);
    chk("R6 no count while high", {cnt_hi, cnt_lo}, 16'd0);
    pin_i = 1'b0; step(128);
    pin_i = 1'b1; step(6);
    chk("R6 two ticks while low", {cnt_hi, cnt_lo}, 16'd2);
    chk("R7 trailing rising edge flag", {15'd0, flag_o}, 16'd1);
    clr_flag();
  endtask

  task automatic t_wr_priority();
    logic [7:0] v;
    int guard;
    edge_sel = 0; pin_i = 1'b1; step(4);
    v = cnt_lo; guard = 0;
    while (cnt_lo == v && guard < 80) begin
      step(1); guard++;
    end
    step(63);
    v = cnt_hi;
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h40;
    step(1);
    wr_en = 1'b0;
    chk("R9 write beats coincident tick", {cnt_hi, cnt_lo}, {v, 8'h40});
    step(64);
    chk("R9 next tick counts normally", {8'h00, cnt_lo}, 16'h0041);
    pin_i = 1'b0; step(4);
    clr_flag();
  endtask

  task automatic t_indep();
    sys_en = 0; mode_gated = 0; edge_sel = 1; pin_i = 0;
    step(4);
    clr_flag();
    lo_en = 1; hi_en = 0;
    wr_byte(0, 8'hFE); wr_byte(1, 8'h05);
    pulses(3);
    chk("R11 R8 low wraps, high held", {cnt_hi, cnt_lo}, 16'h0501);
    chk("R7 no flag when disabled", {15'd0, flag_o}, 16'd0);
    lo_en = 0; hi_en = 1;
    pulses(2);
    chk("R8 only high byte counts", {cnt_hi, cnt_lo}, 16'h0701);
    wr_byte(1, 8'hFF);
    pulses(1);
    chk("R11 high wraps, low held", {cnt_hi, cnt_lo}, 16'h0001);
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 0; pin_i = 0; sys_en = 0; mode_gated = 0; edge_sel = 0;
    lo_en = 0; hi_en = 0; wr_en = 0; wr_sel = 0; wr_data = 8'h00; flag_clr = 0;
    step(4);
    rst_n = 1;
    step(4);
    t_reset();
    t_event_fall();
    t_event_rise();
    t_carry();
    t_gated_high();
    t_gated_low();
    t_wr_priority();
    t_indep();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule